// File: doc/BRIEF.md
# Contiguous Free-Sector Gap Finder

This block looks for room to place a new file on a small save-memory file system where every file must occupy one unbroken run of sectors. The medium has 256 sectors; the lowest two hold the directory, so file data may sit anywhere from sector 2 up to the end of the medium. The directory lists files sorted by ascending start sector, and each entry carries a start sector and a length in sectors.

After a start pulse the block reads the entries one per cycle through a combinational read port. Free space is found only by measuring the distance from the end of one file to the start of the following file. A stored first-free or used-count field is never trusted for this purpose. The lowest hole that can hold the requested length is reported. The run from the last file to the end of the medium counts as a hole too. While it walks the entries the block also adds up their lengths into a used-sector total. A mode input chooses whether the two directory sectors are counted in that total.

Top module: `gapf_scan`

## Requirements
- R1: After reset, done, found, result_start and used_count are all 0.
- R2: done is high for exactly one cycle. It rises N+1 clock edges after the edge that samples start, where N is entry_total.
- R3: A hole between consecutive entries qualifies when the next start minus (previous start + previous count) is at least req_count. An exact fit qualifies. The lowest qualifying hole is reported in result_start, with found = 1.
- R4: The first candidate hole runs from sector 2 to the first entry's start.
- R5: The last candidate hole runs from the end of the last entry to sector 256.
- R6: When no hole qualifies, found = 0 and result_start = 0.
- R7: With entry_total = 0, the result is sector 2 when req_count is 254 or less. A larger request is not found.
- R8: used_count is the sum of all entry counts when count_with_dir = 0. It is that sum plus 2 when count_with_dir = 1, giving 2..256.
- R9: A start pulse that arrives while a scan is in progress is ignored. Only one done follows, and it carries the first request's result.
- R10: found, result_start and used_count hold their values from one done until the next done, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan; sampled only while idle |
| req_count | input | 9 | Number of contiguous sectors wanted |
| entry_total | input | 6 | Number of valid directory entries |
| count_with_dir | input | 1 | 1: used total includes the 2 directory sectors |
| rd_index | output | 5 | Entry index being read |
| rd_start | input | 9 | Start sector of the indexed entry |
| rd_count | input | 9 | Sector count of the indexed entry |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A large enough hole exists |
| result_start | output | 9 | First sector of the chosen hole, 0 if none |
| used_count | output | 9 | Used-sector total in the selected convention |

## Verification
All results arrive together with the done pulse. That pulse comes N+1 edges after the sampling edge of start: one edge per entry, plus one edge to check the hole at the end of the medium. So an empty directory answers on the very next edge, and 32 entries take 33 edges. The bench notes the cycle number at the start-sampling edge. For each request it queues the expected latency along with the expected found, result_start and used_count values. A monitor samples the outputs on falling edges and checks both the latency and the values when done appears. A separate check confirms that the outputs stay unchanged for several cycles after the pulse.

// File: rtl/gapf_pkg.sv
package gapf_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } gapf_state_e;
endpackage

// File: rtl/gapf_hole_fit.sv
// Decides whether the span [lo, hi) is at least `need` sectors long.
module gapf_hole_fit #(
    parameter int W = 9
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] need,
    output logic         fits
);
    logic [W-1:0] span;

    always_comb begin
        span = hi - lo;
        fits = (hi >= lo) && (span >= need);
    end
endmodule

// File: rtl/gapf_used_conv.sv
// Converts the raw sum of entry lengths to the selected used-count convention.
module gapf_used_conv #(
    parameter int W        = 9,
    parameter int DIR_SECS = 2
) (
    input  logic [W-1:0] sum,
    input  logic         with_dir,
    output logic [W-1:0] total
);
    localparam logic [W-1:0] DirOffs = W'(DIR_SECS);

    always_comb begin
        total = with_dir ? (sum + DirOffs) : sum;
    end
endmodule

// File: rtl/gapf_scan.sv
module gapf_scan
    import gapf_pkg::*;
#(
    parameter int SECTORS     = 256,
    parameter int DIR_SECTORS = 2,
    parameter int MAX_ENTRIES = 32,
    localparam int SECW = $clog2(SECTORS + 1),
    localparam int IDXW = $clog2(MAX_ENTRIES),
    localparam int CNTW = $clog2(MAX_ENTRIES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SECW-1:0] req_count,
    input  logic [CNTW-1:0] entry_total,
    input  logic            count_with_dir,
    output logic [IDXW-1:0] rd_index,
    input  logic [SECW-1:0] rd_start,
    input  logic [SECW-1:0] rd_count,
    output logic            done,
    output logic            found,
    output logic [SECW-1:0] result_start,
    output logic [SECW-1:0] used_count
);
    localparam logic [SECW-1:0] FirstFree = SECW'(DIR_SECTORS);
    localparam logic [SECW-1:0] MediumEnd = SECW'(SECTORS);

    typedef struct packed {
        gapf_state_e     state;
        logic [CNTW-1:0] idx;
        logic [CNTW-1:0] total;
        logic [SECW-1:0] cursor;
        logic [SECW-1:0] acc;
        logic [SECW-1:0] req;
        logic            mode;
        logic            hit;
        logic [SECW-1:0] hit_at;
        logic            done;
        logic            out_found;
        logic [SECW-1:0] out_start;
        logic [SECW-1:0] out_used;
    } gapf_regs_t;

    gapf_regs_t r_d, r_q;

    logic            mid_fits;
    logic            tail_fits;
    logic [SECW-1:0] used_conv;

    gapf_hole_fit #(.W(SECW)) u_mid_fit (
        .lo   (r_q.cursor),
        .hi   (rd_start),
        .need (r_q.req),
        .fits (mid_fits)
    );

    gapf_hole_fit #(.W(SECW)) u_tail_fit (
        .lo   (r_q.cursor),
        .hi   (MediumEnd),
        .need (r_q.req),
        .fits (tail_fits)
    );

    gapf_used_conv #(.W(SECW), .DIR_SECS(DIR_SECTORS)) u_used (
        .sum      (r_q.acc),
        .with_dir (r_q.mode),
        .total    (used_conv)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state  = ST_SCAN;
                    r_d.idx    = '0;
                    r_d.total  = entry_total;
                    r_d.cursor = FirstFree;
                    r_d.acc    = '0;
                    r_d.req    = req_count;
                    r_d.mode   = count_with_dir;
                    r_d.hit    = 1'b0;
                    r_d.hit_at = '0;
                end
            end
            ST_SCAN: begin
                if (r_q.idx < r_q.total) begin
                    // one entry per cycle: test the hole in front of it, then move past it
                    if (!r_q.hit && mid_fits) begin
                        r_d.hit    = 1'b1;
                        r_d.hit_at = r_q.cursor;
                    end
                    r_d.cursor = rd_start + rd_count;
                    r_d.acc    = r_q.acc + rd_count;
                    r_d.idx    = r_q.idx + 1'b1;
                end else begin
                    // all entries consumed: the run up to the medium end is the last candidate
                    r_d.state     = ST_IDLE;
                    r_d.done      = 1'b1;
                    r_d.out_found = r_q.hit || tail_fits;
                    if (r_q.hit) begin
                        r_d.out_start = r_q.hit_at;
                    end else if (tail_fits) begin
                        r_d.out_start = r_q.cursor;
                    end else begin
                        r_d.out_start = '0;
                    end
                    r_d.out_used = used_conv;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_index     = r_q.idx[IDXW-1:0];
    assign done         = r_q.done;
    assign found        = r_q.out_found;
    assign result_start = r_q.out_start;
    assign used_count   = r_q.out_used;
endmodule

// File: rtl/gapf_scan_chk.sv
module gapf_scan_chk #(
    parameter int SECTORS     = 256,
    parameter int DIR_SECTORS = 2,
    localparam int SECW = $clog2(SECTORS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic            found,
    input logic [SECW-1:0] result_start,
    input logic [SECW-1:0] used_count,
    input logic [SECW-1:0] req,
    input logic            mode
);
    logic [SECW:0] fit_end;
    assign fit_end = {1'b0, result_start} + {1'b0, req};

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    p_fit_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (result_start >= SECW'(DIR_SECTORS)) && (fit_end <= (SECW+1)'(SECTORS)));

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (result_start == '0));

    p_used_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode) |-> (used_count >= SECW'(DIR_SECTORS)));

    p_scan_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(found) && $stable(result_start) && $stable(used_count)));
endmodule

bind gapf_scan gapf_scan_chk #(.SECTORS(SECTORS), .DIR_SECTORS(DIR_SECTORS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (r_q.state == gapf_pkg::ST_SCAN),
    .done         (done),
    .found        (found),
    .result_start (result_start),
    .used_count   (used_count),
    .req          (r_q.req),
    .mode         (r_q.mode)
);

// File: tb/sim_gapf_scan.sv
`timescale 1ns/1ps
module sim_gapf_scan;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] req_count = '0;
    logic [5:0] entry_total = '0;
    logic       count_with_dir = 1'b0;
    logic [4:0] rd_index;
    logic [8:0] rd_start, rd_count;
    logic       done, found;
    logic [8:0] result_start, used_count;

    logic [8:0] mem_s [32];
    logic [8:0] mem_c [32];

    assign rd_start = mem_s[rd_index];
    assign rd_count = mem_c[rd_index];

    gapf_scan u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_count(req_count),
        .entry_total(entry_total), .count_with_dir(count_with_dir),
        .rd_index(rd_index), .rd_start(rd_start), .rd_count(rd_count),
        .done(done), .found(found), .result_start(result_start), .used_count(used_count)
    );

    always #2 clk = ~clk;

    typedef struct {
        string tag;
        int    lat;
        int    fnd;
        int    st;
        int    used;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   t0 = 0;
    int   done_seen = 0;
    exp_t last;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: pops the expected item when done appears
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk("R9", "unexpected done", 1, 0);
            end else begin
                exp_t it;
                it = q.pop_front();
                chk("R2", {it.tag, " latency"}, cyc - t0, it.lat);
                chk(it.tag, "found", int'(found), it.fnd);
                chk(it.tag, "result_start", int'(result_start), it.st);
                chk("R8", {it.tag, " used_count"}, int'(used_count), it.used);
                last = it;
            end
            done_seen++;
        end
    end

    task automatic run(input int n, input int req, input bit mode, input string tag,
                       input int efnd, input int est, input int eused, input bit bump);
        exp_t it;
        int   s;
        it.tag = tag; it.lat = n + 1; it.fnd = efnd; it.st = est; it.used = eused;
        q.push_back(it);
        s = done_seen;
        @(negedge clk);
        start = 1'b1; req_count = 9'(req); entry_total = 6'(n); count_with_dir = mode;
        @(negedge clk);
        start = 1'b0;
        t0 = cyc;
        if (bump) begin
            @(negedge clk);
            start = 1'b1; req_count = 9'd222; count_with_dir = ~mode;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_seen == s) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        chk("R2", {tag, " done width"}, int'(done), 0);
    endtask

    task automatic load_a();
        mem_s[0] = 9'd2;  mem_c[0] = 9'd3;
        mem_s[1] = 9'd5;  mem_c[1] = 9'd4;
        mem_s[2] = 9'd12; mem_c[2] = 9'd10;
        mem_s[3] = 9'd30; mem_c[3] = 9'd5;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem_s[i] = '0;
            mem_c[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "done", int'(done), 0);
        chk("R1", "found", int'(found), 0);
        chk("R1", "result_start", int'(result_start), 0);
        chk("R1", "used_count", int'(used_count), 0);
        rst_n = 1'b1;

        load_a();
        run(4, 3,   1'b0, "R3 first middle hole", 1, 9,  22, 1'b0);
        run(4, 8,   1'b1, "R3 exact fit",         1, 22, 24, 1'b0);
        run(4, 9,   1'b0, "R5 tail",              1, 35, 22, 1'b0);
        run(4, 221, 1'b0, "R5 tail exact",        1, 35, 22, 1'b0);
        run(4, 222, 1'b1, "R6 no room",           0, 0,  24, 1'b0);

        // R10: outputs hold while inputs wander
        req_count = 9'd1; entry_total = 6'd0; count_with_dir = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10", "found hold", int'(found), last.fnd);
        chk("R10", "result_start hold", int'(result_start), last.st);
        chk("R10", "used_count hold", int'(used_count), last.used);

        // R9: second start during scan ignored
        run(4, 3, 1'b0, "R9 busy start", 1, 9, 22, 1'b1);
        begin
            int s2;
            s2 = done_seen;
            repeat (8) @(negedge clk);
            chk("R9", "extra done count", done_seen - s2, 0);
        end

        mem_s[0] = 9'd10; mem_c[0] = 9'd5;
        run(1, 8, 1'b0, "R4 leading hole", 1, 2,  5, 1'b0);
        run(1, 9, 1'b0, "R4 leading too small", 1, 15, 5, 1'b0);

        run(0, 254, 1'b1, "R7 empty fits", 1, 2, 2, 1'b0);
        run(0, 255, 1'b0, "R7 empty too big", 0, 0, 0, 1'b0);

        mem_s[0] = 9'd2; mem_c[0] = 9'd254;
        run(1, 1, 1'b1, "R6 full medium", 0, 0, 256, 1'b0);
        run(1, 1, 1'b0, "R8 full excl", 0, 0, 254, 1'b0);
        mem_c[0] = 9'd250;
        run(1, 4, 1'b0, "R5 tail to end", 1, 252, 250, 1'b0);

        for (int i = 0; i < 32; i++) begin
            mem_s[i] = 9'(2 + 7 * i);
            mem_c[i] = 9'd6;
        end
        run(32, 1, 1'b0, "R3 many entries", 1, 8,   192, 1'b0);
        run(32, 2, 1'b1, "R5 many entries", 1, 225, 194, 1'b0);

        chk("R2", "queue drained", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(100000 * 4);
        checks++;
        errors++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule